// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces the strobes and the address/data sequence of an 8-bit external memory bus that multiplexes the low address byte with data. It runs directly on the oscillator clock. A machine cycle is twelve clocks long, made of six states of two clocks each. Once per machine cycle, the block samples a request from the CPU side. The request can be a code fetch, a code-table read, an external data read, an external data write, or nothing.

Every clock, the block drives the address latch strobe, the code read strobe, and the data read and write strobes. It also drives a separate port that carries the high address byte. A data access can use a 16-bit pointer, whose high byte appears on the high port, or an 8-bit register address, in which case the high port keeps showing the port's own latch value. Bytes read from the bus are captured and handed back with a one-clock valid pulse.

A quiet-mode input holds the latch strobe high so that it does not toggle on idle and fetch cycles. This input is ignored for data and table cycles, and it is ignored completely while the device executes from external code memory.

Top module: `mbus_seq`

## Requirements
- R1: Counting the clocks of a machine cycle 0 to 11, `ale` is high on counts 0, 1, 6 and 7 and low on all other counts of idle, fetch (op 1) and table (op 2) cycles. This gives one pulse of two clocks every six clocks.
- R2: In a data read (op 3) or data write (op 4) cycle, `ale` is high only on counts 0 and 1. The pulse at count 6 is skipped.
- R3: `psen_n` is low on counts 3–5 and 9–11 of fetch and table cycles, and high throughout idle and data cycles. A data cycle therefore skips two code strobes.
- R4: When `ale_quiet`=1 and `ext_code`=0, `ale` stays high for the whole of idle and fetch cycles. Data and table cycles still show their normal `ale` pattern.
- R5: When `ext_code`=1, `ale_quiet` has no effect on `ale`.
- R6: `rd_n` is low exactly on counts 5–10 of a data read cycle, and `wr_n` is low exactly on counts 5–10 of a data write cycle. The two are never low together.
- R7: In code cycles, `ad_oe` is high on counts 0–2 with `ad_out` equal to the low byte of the address, and on counts 6–8 with `ad_out` equal to the low byte of address+1. In data cycles, `ad_oe` is high on counts 0–2 with the low address byte. A data read releases the bus (`ad_oe`=0) from count 3 on.
- R8: A data write drives `ad_out`=write data with `ad_oe`=1 on counts 3–11, which covers the span from before `wr_n` falls until after it rises.
- R9: `hi_out` carries the high byte of the address in code cycles (the high byte of address+1 on counts 6–11), and the pointer high byte in data cycles with `req_wide`=1. In data cycles with `req_wide`=0, and in idle cycles, it carries `p2_latch`.
- R10: `ad_in` is captured on the last clock of each code strobe and of the read strobe. `rvalid` pulses with that byte on `rdata` at count 6 and at the next count 0 after a code cycle, and at count 11 of a data read cycle.
- R11: During reset (with `ale_quiet`=0), `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `ad_oe`=0, `rvalid`=0 and `slot_end`=1. The first clock edge after reset sampling the request starts the cycle at count 0.
- R12: `slot_end` is high on count 11 only. The request is sampled on that clock edge. `req_valid`=0, or an op code of 5–7, yields an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present for the next machine cycle |
| req_op | input | 3 | 0 idle, 1 fetch, 2 table read, 3 data read, 4 data write |
| req_wide | input | 1 | Data access uses a 16-bit pointer |
| req_addr | input | 16 | Access address (only the low byte is used for narrow data accesses) |
| req_wdata | input | 8 | Write data |
| p2_latch | input | 8 | Contents of the high port's own latch |
| ale_quiet | input | 1 | Hold the latch strobe high when it is not needed |
| ext_code | input | 1 | Device executes from external code memory |
| ad_in | input | 8 | Multiplexed bus input |
| slot_end | output | 1 | Last clock of a machine cycle; the request is sampled here |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Multiplexed bus output value |
| ad_oe | output | 1 | Multiplexed bus output enable |
| hi_out | output | 8 | High address byte port |
| rdata | output | 8 | Captured read byte |
| rvalid | output | 1 | Captured byte is valid this clock |

## Verification
The bench compares every output on every clock against a model built from the requirements. It covers random mixes of all five ops, the illegal op codes and dropped requests, together with random quiet and external-execution settings. Fetch addresses such as 12FF and FFFF check that the second half of a code cycle carries the incremented address into the high byte, which separates an incrementer that crosses bytes from one that does not. Runs of wide and narrow data cycles show whether the high port takes its byte from the pointer or from the latch. Quiet mode applied to idle, table, data and external-execution cycles shows which op types can override quiet mode.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_FETCH  = 3'd1,
        OP_TABLE  = 3'd2,
        OP_DREAD  = 3'd3,
        OP_DWRITE = 3'd4
    } mbus_op_e;

    localparam int STATE_CLKS = 2;
    localparam int STATES     = 6;
    localparam int CYC_LEN    = STATE_CLKS * STATES;
    localparam int HALF_LEN   = CYC_LEN / 2;
    localparam int CNT_W      = $clog2(CYC_LEN);
endpackage

// File: rtl/mbus_timebase.sv
module mbus_timebase
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CYC_LEN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= LAST_C;
        else     cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == LAST_C);
endmodule

// File: rtl/mbus_strobes.sv
module mbus_strobes
    import mbus_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    input  mbus_op_e         op,
    input  logic             quiet,
    input  logic             ext_code,
    output logic             half,
    output logic             ale,
    output logic             psen_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic             addr_phase,
    output logic             wdata_phase,
    output logic             capture
);
    localparam logic [CNT_W-1:0] HALF_C   = CNT_W'(HALF_LEN);
    localparam logic [CNT_W-1:0] ALE_W_C  = CNT_W'(STATE_CLKS);
    localparam logic [CNT_W-1:0] PSEN_C   = CNT_W'(STATE_CLKS + 1);
    localparam logic [CNT_W-1:0] XS_ON_C  = CNT_W'(STATE_CLKS + 3);
    localparam logic [CNT_W-1:0] XS_END_C = CNT_W'(STATE_CLKS + 3 + HALF_LEN - 1);
    localparam logic [CNT_W-1:0] PH_END_C = CNT_W'(HALF_LEN - 1);

    logic [CNT_W-1:0] ph;
    logic             is_code, is_data, xs_win, quiet_eff;

    always_comb begin
        half      = (cnt >= HALF_C);
        ph        = half ? cnt - HALF_C : cnt;
        is_code   = (op == OP_FETCH) || (op == OP_TABLE);
        is_data   = (op == OP_DREAD) || (op == OP_DWRITE);
        xs_win    = (cnt >= XS_ON_C) && (cnt <= XS_END_C);
        quiet_eff = quiet && !ext_code && !is_data && (op != OP_TABLE);

        ale         = quiet_eff || ((ph < ALE_W_C) && !(is_data && half));
        psen_n      = !(is_code && (ph >= PSEN_C));
        rd_n        = !((op == OP_DREAD) && xs_win);
        wr_n        = !((op == OP_DWRITE) && xs_win);
        addr_phase  = (is_code && (ph <= ALE_W_C)) || (is_data && (cnt <= ALE_W_C));
        wdata_phase = (op == OP_DWRITE) && (cnt > ALE_W_C);
        capture     = (is_code && (ph == PH_END_C)) || ((op == OP_DREAD) && (cnt == XS_END_C));
    end
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ADDR_W-DATA_W-1:0] p2_latch,
    input  logic              ale_quiet,
    input  logic              ext_code,
    input  logic [DATA_W-1:0] ad_in,
    output logic              slot_end,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        mbus_op_e          op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wide;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;

    logic [CNT_W-1:0]  cnt;
    logic              last, half, addr_phase, wdata_phase, capture;
    logic              is_code, is_data;
    logic [ADDR_W-1:0] addr_use;

    mbus_timebase u_tb (
        .clk  (clk),
        .rst  (rst),
        .cnt  (cnt),
        .last (last)
    );

    mbus_strobes u_st (
        .cnt         (cnt),
        .op          (s_q.op),
        .quiet       (ale_quiet),
        .ext_code    (ext_code),
        .half        (half),
        .ale         (ale),
        .psen_n      (psen_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .addr_phase  (addr_phase),
        .wdata_phase (wdata_phase),
        .capture     (capture)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = capture;
        if (capture) s_d.rdata = ad_in;
        if (last) begin
            s_d.op    = (req_valid && (req_op <= 3'd4)) ? mbus_op_e'(req_op) : OP_IDLE;
            s_d.addr  = req_addr;
            s_d.wdata = req_wdata;
            s_d.wide  = req_wide;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{op: OP_IDLE, addr: '0, wdata: '0, wide: 1'b0, rvalid: 1'b0, rdata: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        is_code  = (s_q.op == OP_FETCH) || (s_q.op == OP_TABLE);
        is_data  = (s_q.op == OP_DREAD) || (s_q.op == OP_DWRITE);
        addr_use = (is_code && half) ? s_q.addr + 1'b1 : s_q.addr;
        ad_out   = wdata_phase ? s_q.wdata : addr_use[DATA_W-1:0];
        ad_oe    = addr_phase || wdata_phase;
        if (is_code)                 hi_out = addr_use[ADDR_W-1:DATA_W];
        else if (is_data && s_q.wide) hi_out = s_q.addr[ADDR_W-1:DATA_W];
        else                         hi_out = p2_latch[HI_W-1:0];
    end

    assign slot_end = last;
    assign rdata    = s_q.rdata;
    assign rvalid   = s_q.rvalid;
endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk (
    input logic clk,
    input logic rst,
    input logic slot_end,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe
);
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n)); // R6
    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> ($past(rd_n, 6) == 1'b0) && ($past(rd_n, 7) == 1'b1)); // R6
    AST_NO_STROBE_AT_START: assert property (@(posedge clk) disable iff (rst)
        slot_end |=> (rd_n && wr_n && !ale == 1'b0 || rd_n && wr_n)); // R6
    AST_PSEN_NOT_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> (rd_n && wr_n)); // R3
    AST_WR_BUS_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe); // R8
    AST_RD_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe); // R7
endmodule

bind mbus_seq mbus_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .slot_end (slot_end),
    .ale      (ale),
    .psen_n   (psen_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ad_oe    (ad_oe)
);

// File: tb/mbus_seq_bench.sv
module mbus_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic        req_wide = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic [7:0]  p2_latch = 8'h0;
    logic        ale_quiet = 1'b0;
    logic        ext_code = 1'b0;
    logic [7:0]  ad_in = 8'h0;
    logic        slot_end, ale, psen_n, rd_n, wr_n, ad_oe, rvalid;
    logic [7:0]  ad_out, hi_out, rdata;

    int checks = 0;
    int fails  = 0;
    int prev_op = 0;
    logic [7:0] prev_bus = 8'h0;

    always #10 clk = ~clk;

    mbus_seq u_mbus_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .p2_latch(p2_latch), .ale_quiet(ale_quiet), .ext_code(ext_code),
        .ad_in(ad_in), .slot_end(slot_end), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .hi_out(hi_out), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_code(int op); return op == 1 || op == 2; endfunction
    function automatic bit is_data(int op); return op == 3 || op == 4; endfunction

    function automatic bit e_ale(int c, int op, bit q, bit x);
        if (q && !x && !is_data(op) && op != 2) return 1'b1;
        return ((c % 6) < 2) && !(is_data(op) && c >= 6);
    endfunction

    function automatic bit e_oe(int c, int op);
        return (is_code(op) && (c % 6) <= 2) || (is_data(op) && c <= 2) || (op == 4 && c >= 3);
    endfunction

    function automatic logic [7:0] e_ad(int c, int op, logic [15:0] a, logic [7:0] w);
        logic [15:0] n = a + 16'd1;
        if (op == 4 && c >= 3) return w;
        if (is_code(op) && c >= 6) return n[7:0];
        return a[7:0];
    endfunction

    function automatic logic [7:0] e_hi(int c, int op, logic [15:0] a, bit wd, logic [7:0] p2);
        logic [15:0] n = a + 16'd1;
        if (is_code(op)) return (c >= 6) ? n[15:8] : a[15:8];
        if (is_data(op) && wd) return a[15:8];
        return p2;
    endfunction

    task automatic do_cycle(input bit v, input int opi, input logic [15:0] a, input bit wd,
                            input logic [7:0] w, input logic [7:0] p2, input bit q,
                            input bit x, input logic [7:0] busv);
        int op = (v && opi <= 4) ? opi : 0;
        bit e_rv;
        req_valid = v; req_op = 3'(opi); req_addr = a; req_wide = wd;
        req_wdata = w; p2_latch = p2; ale_quiet = q; ext_code = x;
        rst = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R12 slot_end", 16'(slot_end), 16'(i == 11));
            chk(is_data(op) ? "R2/R4/R5 ale" : "R1/R4/R5 ale", 16'(ale), 16'(e_ale(i, op, q, x)));
            chk("R3 psen_n", 16'(psen_n), 16'(!(is_code(op) && (i % 6) >= 3)));
            chk("R6 rd_n", 16'(rd_n), 16'(!(op == 3 && i >= 5 && i <= 10)));
            chk("R6 wr_n", 16'(wr_n), 16'(!(op == 4 && i >= 5 && i <= 10)));
            chk("R7/R8 ad_oe", 16'(ad_oe), 16'(e_oe(i, op)));
            if (e_oe(i, op)) chk("R7/R8 ad_out", 16'(ad_out), 16'(e_ad(i, op, a, w)));
            chk("R9 hi_out", 16'(hi_out), 16'(e_hi(i, op, a, wd, p2)));
            e_rv = (i == 6 && is_code(op)) || (i == 11 && op == 3) || (i == 0 && is_code(prev_op));
            chk("R10 rvalid", 16'(rvalid), 16'(e_rv));
            if (e_rv) chk("R10 rdata", 16'(rdata), 16'((i == 0) ? prev_bus : busv));
            if (i == 2) ad_in = busv;
        end
        prev_op = op;
        prev_bus = busv;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 ale", 16'(ale), 16'd0);
        chk("R11 psen_n", 16'(psen_n), 16'd1);
        chk("R11 rd_n", 16'(rd_n), 16'd1);
        chk("R11 wr_n", 16'(wr_n), 16'd1);
        chk("R11 ad_oe", 16'(ad_oe), 16'd0);
        chk("R11 rvalid", 16'(rvalid), 16'd0);
        chk("R11 slot_end", 16'(slot_end), 16'd1);
        // directed corners
        do_cycle(1, 1, 16'h12FF, 0, 8'h00, 8'hA5, 0, 1, 8'h3C); // R7 R9 carry into high byte
        do_cycle(1, 1, 16'hFFFF, 0, 8'h00, 8'hA5, 0, 1, 8'hC3); // wrap
        do_cycle(1, 3, 16'h4321, 1, 8'h00, 8'h5A, 0, 0, 8'h77); // R2 wide read
        do_cycle(1, 4, 16'h8765, 0, 8'h9E, 8'h5A, 0, 0, 8'h11); // R8 narrow write
        do_cycle(1, 0, 16'h0000, 0, 8'h00, 8'h66, 1, 0, 8'h22); // R4 quiet idle
        do_cycle(1, 2, 16'h0F00, 0, 8'h00, 8'h66, 1, 0, 8'h44); // R4 table overrides quiet
        do_cycle(1, 3, 16'h0033, 0, 8'h00, 8'h66, 1, 0, 8'h55); // R4 data overrides quiet
        do_cycle(1, 1, 16'h2000, 0, 8'h00, 8'h66, 1, 1, 8'h88); // R5 quiet ignored
        do_cycle(1, 7, 16'h1234, 1, 8'h00, 8'h99, 0, 0, 8'h99); // R12 illegal op
        do_cycle(0, 3, 16'h1234, 1, 8'h00, 8'h99, 0, 0, 8'hAA); // R12 no request
        for (int k = 0; k < 60; k++) begin
            do_cycle(bit'($urandom_range(0, 7) != 0), int'($urandom_range(0, 5)),
                     16'($urandom), bit'($urandom), 8'($urandom), 8'($urandom),
                     bit'($urandom_range(0, 3) == 0), bit'($urandom), 8'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule